// File: doc/BRIEF.md
# CAN Bit Timing and Sampling Unit

This unit derives the bit timing of a CAN node from the system clock and samples the receive line once per bit. A programmable divider turns the system clock into time-quantum ticks. A segment sequencer then counts quanta through four segments in order: a one-quantum synchronisation segment, a propagation segment, a first phase segment and a second phase segment. The receive line is captured when the first phase segment ends. A strobe marks the start of every bit, so the transmit path can launch its next bit there.

While idle, the unit waits for a recessive-to-dominant transition on the receive line and aligns to it with a hard synchronisation. Inside a frame it corrects drift with soft resynchronisation. A late edge lengthens the first phase segment and an early edge shortens the second phase segment. The correction is bounded by a programmable jump width and is applied at most once per bit. A synchronous bus-idle request, or an illegal timing configuration, returns the unit to idle.

Top module: `can_bit_timing`

## Requirements
- R1: One quantum lasts `brp+1` system clocks. A bit without resynchronisation lasts `(1+prop_len+ph1_len+ph2_len)*(brp+1)` clocks between consecutive `bit_start` pulses.
- R2: When idle with `hs_en` high and a valid configuration, a 1-to-0 change of `rx` between two clock edges starts a bit. `bit_start` and `busy` are high in the very next cycle, and that cycle is the first cycle of the synchronisation segment.
- R3: `sample_valid` pulses for one cycle at clock offset `(1+prop_len+ph1_len)*(brp+1)` from the `bit_start` cycle of the same bit. `sample_bit` then holds the value `rx` had in the preceding cycle (1 = recessive, 0 = dominant).
- R4: `cfg_valid` is 1 exactly when all of these hold: `prop_len`, `ph1_len` and `ph2_len` are nonzero; `sjw` is in 1..4 and not above `ph2_len`; and the total `1+prop_len+ph1_len+ph2_len` is in 6..16.
- R5: While `cfg_valid` is 0 the unit stays idle. `busy`, `bit_start` and `sample_valid` stay 0.
- R6: With `hs_en` low, a falling `rx` edge while idle starts nothing.
- R7: A falling edge that comes `e` quanta after the end of the synchronisation segment, seen in the propagation or first phase segment, lengthens that bit's first phase segment by `min(e, sjw)` quanta. Here `e` = 1 for the first propagation quantum.
- R8: A falling edge seen in the second phase segment, with `r` quanta of that segment remaining (counting the current one), shortens it by `min(r, sjw)` quanta. When `r <= sjw`, the next quantum starts the next bit.
- R9: Only the first falling edge of a bit resynchronises it. Rising edges never change the timing.
- R10: A high `bus_idle` at a clock edge returns the unit to idle in the next cycle. It then waits for a new hard-synchronisation edge.
- R11: `bit_start` and `sample_valid` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| brp | input | BRP_W | Prescaler value; quantum = brp+1 clocks |
| prop_len | input | 4 | Propagation segment length in quanta |
| ph1_len | input | 3 | First phase segment length in quanta |
| ph2_len | input | 3 | Second phase segment length in quanta |
| sjw | input | 3 | Resynchronisation jump width in quanta (1..4) |
| hs_en | input | 1 | Enables hard synchronisation while idle |
| bus_idle | input | 1 | Synchronous request to return to idle |
| rx | input | 1 | Receive line, 1 = recessive |
| cfg_valid | output | 1 | Timing configuration is legal |
| busy | output | 1 | Unit is inside a frame (not idle) |
| bit_start | output | 1 | One-cycle pulse in the first cycle of each bit |
| sample_valid | output | 1 | One-cycle pulse when a bit has been sampled |
| sample_bit | output | 1 | Sampled receive value |

## Verification
A wrong quantum count or segment pointer shows up within one bit time. `bit_start` or `sample_valid` lands on the wrong cycle, and every later bit is offset by the same amount until the next hard synchronisation. A stuck resynchronisation flag or a wrong stored correction shows up only after a falling edge inside a frame. Its effect is a shifted sample point in that bit and a shifted start of the next bit, so the directed edge tests compare exact cycle positions against values worked out from the segment lengths. A wrong legality decision shows up at once on `cfg_valid`, and the near-exhaustive sweep covers every field combination.

// File: rtl/cbt_pkg.sv
package cbt_pkg;

    localparam int PROP_W = 4;
    localparam int PH_W   = 3;
    localparam int SJW_W  = 3;
    localparam int CNT_W  = 5;
    localparam int TOT_W  = 6;
    localparam int Q_MIN  = 6;
    localparam int Q_MAX  = 16;
    localparam int SJW_MAX = 4;

    typedef enum logic [2:0] {
        SEG_IDLE,
        SEG_SYNC,
        SEG_PROP,
        SEG_PH1,
        SEG_PH2
    } seg_e;

    typedef struct packed {
        logic [PROP_W-1:0] prop;
        logic [PH_W-1:0]   ph1;
        logic [PH_W-1:0]   ph2;
        logic [SJW_W-1:0]  sjw;
    } bt_cfg_t;

    function automatic logic [CNT_W-1:0] q_min(input logic [CNT_W-1:0] a,
                                               input logic [CNT_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [TOT_W-1:0] bit_quanta(input bt_cfg_t c);
        return TOT_W'(1) + TOT_W'(c.prop) + TOT_W'(c.ph1) + TOT_W'(c.ph2);
    endfunction

endpackage

// File: rtl/cbt_cfg_check.sv
module cbt_cfg_check
    import cbt_pkg::*;
(
    input  bt_cfg_t cfg,
    output logic    ok
);
    logic [TOT_W-1:0] tot;
    logic             seg_nz;
    logic             sjw_ok;
    logic             tot_ok;

    always_comb begin
        tot    = bit_quanta(cfg);
        seg_nz = (cfg.prop != '0) && (cfg.ph1 != '0) && (cfg.ph2 != '0);
        sjw_ok = (cfg.sjw != '0) && (cfg.sjw <= SJW_W'(SJW_MAX))
                 && (CNT_W'(cfg.sjw) <= CNT_W'(cfg.ph2));
        tot_ok = (tot >= TOT_W'(Q_MIN)) && (tot <= TOT_W'(Q_MAX));
        ok     = seg_nz && sjw_ok && tot_ok;
    end

endmodule

// File: rtl/cbt_prescaler.sv
module cbt_prescaler #(
    parameter int W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic [W-1:0] div,
    output logic         tick
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (cnt >= div) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + W'(1);
        end
    end

    assign tick = run && (cnt >= div);

endmodule

// File: rtl/cbt_edge_det.sv
module cbt_edge_det (
    input  logic clk,
    input  logic rst,
    input  logic rx,
    output logic fall
);
    logic rx_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_prev <= 1'b1;
        end else begin
            rx_prev <= rx;
        end
    end

    assign fall = rx_prev && !rx;

endmodule

// File: rtl/cbt_seq.sv
module cbt_seq
    import cbt_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  bt_cfg_t cfg,
    input  logic    cfg_ok,
    input  logic    hs_en,
    input  logic    bus_idle,
    input  logic    tick,
    input  logic    fall,
    input  logic    rx,
    output logic    busy,
    output logic    bit_start,
    output logic    sample_valid,
    output logic    sample_bit
);
    seg_e             seg;
    logic [CNT_W-1:0] qcnt;
    logic [CNT_W-1:0] ext;
    logic [CNT_W-1:0] shr;
    logic             resynced;

    logic             do_resync;
    logic [CNT_W-1:0] sjw_q;
    logic [CNT_W-1:0] err_late;
    logic [CNT_W-1:0] err_early;
    logic [CNT_W-1:0] ext_eff;
    logic [CNT_W-1:0] shr_eff;
    logic [CNT_W-1:0] seg_len;
    logic             seg_last;

    always_comb begin
        sjw_q     = CNT_W'(cfg.sjw);
        do_resync = fall && !resynced
                    && (seg == SEG_PROP || seg == SEG_PH1 || seg == SEG_PH2);
        if (seg == SEG_PROP) begin
            err_late = qcnt + CNT_W'(1);
        end else begin
            err_late = CNT_W'(cfg.prop) + qcnt + CNT_W'(1);
        end
        err_early = CNT_W'(cfg.ph2) - qcnt;
        ext_eff   = ext;
        shr_eff   = shr;
        if (do_resync && seg != SEG_PH2) begin
            ext_eff = q_min(err_late, sjw_q);
        end
        if (do_resync && seg == SEG_PH2) begin
            shr_eff = q_min(err_early, sjw_q);
        end
        case (seg)
            SEG_PROP: seg_len = CNT_W'(cfg.prop);
            SEG_PH1:  seg_len = CNT_W'(cfg.ph1) + ext_eff;
            SEG_PH2:  seg_len = CNT_W'(cfg.ph2) - shr_eff;
            default:  seg_len = CNT_W'(1);
        endcase
        seg_last = (qcnt + CNT_W'(1)) >= seg_len;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            seg          <= SEG_IDLE;
            qcnt         <= '0;
            ext          <= '0;
            shr          <= '0;
            resynced     <= 1'b0;
            bit_start    <= 1'b0;
            sample_valid <= 1'b0;
            sample_bit   <= 1'b1;
        end else begin
            bit_start    <= 1'b0;
            sample_valid <= 1'b0;
            if (bus_idle || !cfg_ok) begin
                seg      <= SEG_IDLE;
                qcnt     <= '0;
                ext      <= '0;
                shr      <= '0;
                resynced <= 1'b0;
            end else if (seg == SEG_IDLE) begin
                if (hs_en && fall) begin
                    seg       <= SEG_SYNC;
                    qcnt      <= '0;
                    ext       <= '0;
                    shr       <= '0;
                    resynced  <= 1'b0;
                    bit_start <= 1'b1;
                end
            end else begin
                if (do_resync) begin
                    ext      <= ext_eff;
                    shr      <= shr_eff;
                    resynced <= 1'b1;
                end
                if (tick) begin
                    if (seg_last) begin
                        qcnt <= '0;
                        case (seg)
                            SEG_SYNC: seg <= SEG_PROP;
                            SEG_PROP: seg <= SEG_PH1;
                            SEG_PH1: begin
                                seg          <= SEG_PH2;
                                sample_valid <= 1'b1;
                                sample_bit   <= rx;
                            end
                            default: begin
                                seg       <= SEG_SYNC;
                                bit_start <= 1'b1;
                                ext       <= '0;
                                shr       <= '0;
                                resynced  <= 1'b0;
                            end
                        endcase
                    end else begin
                        qcnt <= qcnt + CNT_W'(1);
                    end
                end
            end
        end
    end

    assign busy = (seg != SEG_IDLE);

endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
    import cbt_pkg::*;
#(
    parameter int BRP_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BRP_W-1:0]     brp,
    input  logic [PROP_W-1:0]    prop_len,
    input  logic [PH_W-1:0]      ph1_len,
    input  logic [PH_W-1:0]      ph2_len,
    input  logic [SJW_W-1:0]     sjw,
    input  logic                 hs_en,
    input  logic                 bus_idle,
    input  logic                 rx,
    output logic                 cfg_valid,
    output logic                 busy,
    output logic                 bit_start,
    output logic                 sample_valid,
    output logic                 sample_bit
);
    bt_cfg_t cfg;
    logic    tick;
    logic    fall;

    assign cfg = '{prop: prop_len, ph1: ph1_len, ph2: ph2_len, sjw: sjw};

    cbt_cfg_check u_cfg (
        .cfg (cfg),
        .ok  (cfg_valid)
    );

    cbt_prescaler #(.W(BRP_W)) u_psc (
        .clk  (clk),
        .rst  (rst),
        .run  (busy),
        .div  (brp),
        .tick (tick)
    );

    cbt_edge_det u_edge (
        .clk  (clk),
        .rst  (rst),
        .rx   (rx),
        .fall (fall)
    );

    cbt_seq u_seq (
        .clk          (clk),
        .rst          (rst),
        .cfg          (cfg),
        .cfg_ok       (cfg_valid),
        .hs_en        (hs_en),
        .bus_idle     (bus_idle),
        .tick         (tick),
        .fall         (fall),
        .rx           (rx),
        .busy         (busy),
        .bit_start    (bit_start),
        .sample_valid (sample_valid),
        .sample_bit   (sample_bit)
    );

endmodule

// File: rtl/cbt_checker.sv
module cbt_checker (
    input logic clk,
    input logic rst,
    input logic rx,
    input logic hs_en,
    input logic bus_idle,
    input logic cfg_valid,
    input logic busy,
    input logic bit_start,
    input logic sample_valid
);
    logic rx_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_seen <= 1'b1;
        end else begin
            rx_seen <= rx;
        end
    end

    p_strobes_apart_r11: assert property (@(posedge clk) disable iff (rst)
        !(bit_start && sample_valid));

    p_invalid_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !cfg_valid |=> !busy);

    p_quiet_when_idle_r5: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!bit_start && !sample_valid));

    p_bus_idle_r10: assert property (@(posedge clk) disable iff (rst)
        bus_idle |=> !busy);

    p_hard_sync_r2: assert property (@(posedge clk) disable iff (rst)
        (!busy && cfg_valid && hs_en && !bus_idle && rx_seen && !rx)
        |=> (bit_start && busy));

    p_no_hs_r6: assert property (@(posedge clk) disable iff (rst)
        (!busy && !hs_en) |=> !bit_start);

endmodule

bind can_bit_timing cbt_checker u_chk (
    .clk          (clk),
    .rst          (rst),
    .rx           (rx),
    .hs_en        (hs_en),
    .bus_idle     (bus_idle),
    .cfg_valid    (cfg_valid),
    .busy         (busy),
    .bit_start    (bit_start),
    .sample_valid (sample_valid)
);

// File: tb/can_bit_timing_test.sv
module can_bit_timing_test;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] brp;
    logic [3:0] prop_len;
    logic [2:0] ph1_len;
    logic [2:0] ph2_len;
    logic [2:0] sjw;
    logic       hs_en;
    logic       bus_idle;
    logic       rx;
    logic       cfg_valid;
    logic       busy;
    logic       bit_start;
    logic       sample_valid;
    logic       sample_bit;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int   bs_c[4];
    int   sv_c[4];
    logic sv_b[4];
    int   nbs;
    int   nsv;
    int   nbusy;

    always #10 clk = ~clk;

    can_bit_timing uut (
        .clk          (clk),
        .rst          (rst),
        .brp          (brp),
        .prop_len     (prop_len),
        .ph1_len      (ph1_len),
        .ph2_len      (ph2_len),
        .sjw          (sjw),
        .hs_en        (hs_en),
        .bus_idle     (bus_idle),
        .rx           (rx),
        .cfg_valid    (cfg_valid),
        .busy         (busy),
        .bit_start    (bit_start),
        .sample_valid (sample_valid),
        .sample_bit   (sample_bit)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int b, input int p, input int a, input int z, input int j);
        brp      = 6'(b);
        prop_len = 4'(p);
        ph1_len  = 3'(a);
        ph2_len  = 3'(z);
        sjw      = 3'(j);
    endtask

    // Idle the unit, then drive a falling edge; cycle 0 is the cycle after it.
    // pat[c] is the rx value held during cycle c.
    task automatic run_frame(input int ncyc, input logic [127:0] pat);
        nbs = 0; nsv = 0; nbusy = 0;
        for (int i = 0; i < 4; i++) begin
            bs_c[i] = -1; sv_c[i] = -1; sv_b[i] = 1'bx;
        end
        @(negedge clk); bus_idle = 1'b1; rx = 1'b1;
        @(negedge clk); bus_idle = 1'b0;
        @(negedge clk);
        rx = 1'b0;
        for (int c = 0; c < ncyc; c++) begin
            @(negedge clk);
            if (busy) nbusy++;
            if (bit_start) begin
                if (nbs < 4) bs_c[nbs] = c;
                nbs++;
            end
            if (sample_valid) begin
                if (nsv < 4) begin
                    sv_c[nsv] = c;
                    sv_b[nsv] = sample_bit;
                end
                nsv++;
            end
            rx = pat[c];
        end
    endtask

    function automatic logic [127:0] steady_then_high(input int from);
        logic [127:0] p;
        for (int i = 0; i < 128; i++) p[i] = (i >= from);
        return p;
    endfunction

    initial begin
        #4000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [127:0] pat;
        rst = 1'b1; hs_en = 1'b1; bus_idle = 1'b0; rx = 1'b1;
        set_cfg(0, 11, 2, 2, 1);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // Reset state
        chk(!busy && !bit_start && !sample_valid, "R2 reset idle", int'(busy), 0);

        // R4: sweep all field combinations
        for (int p = 0; p < 16; p++)
            for (int a = 0; a < 8; a++)
                for (int z = 0; z < 8; z++)
                    for (int j = 0; j < 8; j++) begin
                        int tot;
                        bit exp;
                        set_cfg(0, p, a, z, j);
                        #1;
                        tot = 1 + p + a + z;
                        exp = (p != 0) && (a != 0) && (z != 0) && (j >= 1) && (j <= 4)
                              && (j <= z) && (tot >= 6) && (tot <= 16);
                        chk(cfg_valid == exp, "R4 cfg_valid", int'(cfg_valid), int'(exp));
                    end

        // R1 R2 R3: timing sweep over prescaler and segment lengths
        for (int b = 0; b < 3; b++)
            for (int p = 1; p < 5; p++)
                for (int a = 1; a < 4; a++)
                    for (int z = 1; z < 4; z++) begin
                        int t, s, q;
                        t = 1 + p + a + z;
                        if (t < 6) continue;
                        q = b + 1;
                        s = 1 + p + a;
                        set_cfg(b, p, a, z, 1);
                        run_frame(2 * t * q, steady_then_high(t * q));
                        chk(bs_c[0] == 0, "R2 hard sync start", bs_c[0], 0);
                        chk(bs_c[1] == t * q, "R1 bit length", bs_c[1], t * q);
                        chk(nbs == 2, "R1 bit count", nbs, 2);
                        chk(sv_c[0] == s * q, "R3 sample point", sv_c[0], s * q);
                        chk(sv_c[1] == t * q + s * q, "R3 sample point bit 1", sv_c[1], t * q + s * q);
                        chk(sv_b[0] == 1'b0, "R3 sampled dominant", int'(sv_b[0]), 0);
                        chk(sv_b[1] == 1'b1, "R3 sampled recessive", int'(sv_b[1]), 1);
                    end

        // R7 R9: late edges, prop=3 ph1=2 ph2=3, quantum = 1 clock
        pat = '0;
        for (int i = 3; i <= 10; i++) pat[i] = 1'b1;
        pat[12] = 1'b1;
        set_cfg(0, 3, 2, 3, 2);
        run_frame(24, pat);
        chk(sv_c[1] == 17, "R7 lengthened ph1 sample", sv_c[1], 17);
        chk(bs_c[2] == 20, "R9 second fall ignored", bs_c[2], 20);
        chk(sv_b[0] == 1'b1, "R3 sampled value", int'(sv_b[0]), 1);
        set_cfg(0, 3, 2, 3, 1);
        run_frame(24, pat);
        chk(sv_c[1] == 16, "R7 jump width limit", sv_c[1], 16);
        chk(bs_c[2] == 19, "R7 jump width limit next bit", bs_c[2], 19);

        // R8: early edge at the first ph2 quantum
        pat = '0;
        for (int i = 2; i <= 5; i++) pat[i] = 1'b1;
        set_cfg(0, 3, 2, 3, 2);
        run_frame(20, pat);
        chk(bs_c[1] == 7, "R8 shortened ph2", bs_c[1], 7);
        chk(sv_c[1] == 13, "R8 following sample", sv_c[1], 13);
        chk(bs_c[2] == 16, "R8 following bit", bs_c[2], 16);
        set_cfg(0, 3, 2, 3, 1);
        run_frame(20, pat);
        chk(bs_c[1] == 8, "R8 jump width limit", bs_c[1], 8);
        chk(sv_c[1] == 14, "R8 jump width limit sample", sv_c[1], 14);

        // R9: rising edges only, no timing change
        pat = '0;
        for (int i = 0; i < 128; i++) pat[i] = (i >= 11);
        run_frame(20, pat);
        chk(bs_c[1] == 9 && bs_c[2] == 18, "R9 rising edge ignored", bs_c[2], 18);

        // R6: hard sync disabled
        hs_en = 1'b0;
        run_frame(30, '0);
        chk(nbs == 0 && nbusy == 0, "R6 no start without enable", nbs, 0);
        hs_en = 1'b1;

        // R5: illegal configuration (total 4 quanta)
        set_cfg(0, 1, 1, 1, 1);
        run_frame(30, '0);
        chk(nbs == 0 && nsv == 0 && nbusy == 0, "R5 held idle", nbs + nsv + nbusy, 0);

        // R10: bus_idle mid-frame
        set_cfg(1, 5, 2, 2, 1);
        run_frame(5, '0);
        chk(busy == 1'b1, "R10 in frame", int'(busy), 1);
        bus_idle = 1'b1;
        @(negedge clk);
        bus_idle = 1'b0;
        chk(busy == 1'b0, "R10 returned idle", int'(busy), 0);
        begin
            int cnt = 0;
            for (int c = 0; c < 40; c++) begin
                @(negedge clk);
                if (bit_start || sample_valid || busy) cnt++;
            end
            chk(cnt == 0, "R10 stays idle", cnt, 0);
        end
        rx = 1'b1;
        @(negedge clk);
        rx = 1'b0;
        @(negedge clk);
        chk(bit_start == 1'b1, "R2 hard sync after idle", int'(bit_start), 1);
        chk(!(bit_start && sample_valid), "R11 exclusive strobes", int'(sample_valid), 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule